// File: doc/BRIEF.md
# SMBus Block Transfer Byte-Handshake Engine

This engine sits on the host side of an SMBus link and runs block write and block read commands. It has no payload buffer. Each data byte moves through one shared data register. A byte-done flag gates every step: hardware sets the flag, and software clears it. Software fills in a target register (7-bit address and direction), a command, and a count, then writes a start strobe. The engine walks through the protocol phases and issues byte-level operations to a bit-level SMBus master below it. That master executes each operation and reports completion.

On a block write, the engine sends the address, the command and the count register. It then sends one payload byte at a time from the data register. On a block read, it captures the count the slave returns, then delivers each payload byte into the data register. While software owes a response, the engine parks in a wait state and drives an SCL-hold request. The bus therefore stalls instead of dropping data. A level interrupt follows the byte-done flag when the interrupt is enabled. A count of zero is treated as an error in both directions, as is a not-acknowledge from the slave.

Top module: `smb_blk_xfer`

## Requirements
- R1: Register offsets are as follows. Reads are combinational, and every flag is 0 after reset.
  - 0 is the target: bits 7:1 hold the address, and bit 0 is the direction (1 = read).
  - 1 is the command.
  - 2 is the count.
  - 3 is the data register.
  - 4 is control: bit 0 is the start strobe, and bit 1 is the interrupt enable, which reads back.
  - 5 is status: bit 0 is byte-done, bit 1 is error, and bit 2 is busy.
- R2: Operation codes on the master interface are START=0, WRITE=1, READ=2, ACK=3, NACK=4 and STOP=5. START and WRITE carry a byte. A block write issues START with {address,0}, then WRITE command, then WRITE count, then one WRITE per counted byte taken from the data register, then STOP.
- R3: After each block-write data byte completes, byte-done is set. The next data byte is not requested until software clears byte-done by writing 1 to status bit 0. While the engine waits, the SCL-hold output is high.
- R4: A block read issues the following, in order:
  - START with {address,0}, then WRITE command.
  - START with {address,1}, then READ for the count, then ACK.
  - For each counted byte, READ followed by ACK. The last byte gets NACK instead of ACK.
  - STOP.

  The received count is readable in the count register.
- R5: Each received data byte is placed in the data register and byte-done is set. The acknowledge phase and the next READ are withheld, with SCL held, until software clears byte-done.
- R6: A start strobe with direction write and a count register of 0 sets error. It issues no operation, and busy stays low.
- R7: A received count of 0 is answered with NACK then STOP, and error is set.
- R8: A slave not-acknowledge on any START or WRITE is followed directly by STOP. Error is set and byte-done is left clear.
- R9: The interrupt output is a level equal to byte-done AND interrupt enable.
- R10: A start strobe written while busy is ignored: it neither restarts the transfer nor clears the flags.
- R11: An accepted start strobe clears byte-done and error. If hardware stores the count or data register in the same cycle that software writes it, the hardware value wins.
- R12: Each operation request is a one-cycle pulse. Only one request is outstanding at a time, and the engine waits for the done pulse before issuing the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| irq_o | output | 1 | Level interrupt: byte-done and enable |
| phy_req_o | output | 1 | One-cycle operation request to the bit-level master |
| phy_op_o | output | 3 | Operation code |
| phy_byte_o | output | 8 | Byte for START/WRITE |
| phy_done_i | input | 1 | Operation complete pulse |
| phy_nack_i | input | 1 | Slave did not acknowledge (valid with done) |
| phy_rbyte_i | input | 8 | Byte received by READ (valid with done) |
| scl_hold_o | output | 1 | Request to hold SCL low while waiting for software |

## Verification
Two pairs of events can land in the same clock cycle.

- **Count store against a software count write.** The bit-level master can return the count byte of a read in the same cycle that software writes the count register. The bench provokes this by timing a count-register write of 0xEE to coincide exactly with the done pulse of the first READ. It then judges the result by reading back the received count.
- **Error set against error clear.** A zero-count write start sets error in the very cycle the accepted strobe clears the flags. The bench judges this through the status register, which must show error set and busy low. It also checks that the next valid start clears the error.

// File: rtl/smb_blk_pkg.sv
package smb_blk_pkg;
  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] RA_TGT  = 3'd0;
  localparam logic [REG_AW-1:0] RA_CMD  = 3'd1;
  localparam logic [REG_AW-1:0] RA_CNT  = 3'd2;
  localparam logic [REG_AW-1:0] RA_DATA = 3'd3;
  localparam logic [REG_AW-1:0] RA_CTRL = 3'd4;
  localparam logic [REG_AW-1:0] RA_STAT = 3'd5;

  localparam int CTRL_GO   = 0;
  localparam int CTRL_IE   = 1;
  localparam int STAT_DONE = 0;
  localparam int STAT_ERR  = 1;
  localparam int STAT_BUSY = 2;

  typedef enum logic [2:0] {
    OP_START = 3'd0,
    OP_WRITE = 3'd1,
    OP_READ  = 3'd2,
    OP_ACK   = 3'd3,
    OP_NACK  = 3'd4,
    OP_STOP  = 3'd5
  } phy_op_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADR, ST_CMD, ST_CNT, ST_WDAT, ST_WWAIT,
    ST_RSTA, ST_RCNT, ST_RCACK, ST_RZNAK, ST_RDAT, ST_RWAIT,
    ST_RACK, ST_STOP
  } seq_st_e;
endpackage

// File: rtl/smb_blk_regs.sv
module smb_blk_regs
  import smb_blk_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              busy_i,
  input  logic              hw_done_set_i,
  input  logic              hw_err_set_i,
  input  logic              hw_cnt_we_i,
  input  logic              hw_data_we_i,
  input  logic [DW-1:0]     hw_byte_i,
  output logic [DW-1:0]     tgt_o,
  output logic [DW-1:0]     cmd_o,
  output logic [DW-1:0]     cnt_o,
  output logic [DW-1:0]     data_o,
  output logic              done_o,
  output logic              err_o,
  output logic              ie_o,
  output logic              go_o
);
  logic wr_tgt, wr_cmd, wr_cnt, wr_data, wr_ctrl, wr_stat;

  assign wr_tgt  = we_i && (addr_i == RA_TGT);
  assign wr_cmd  = we_i && (addr_i == RA_CMD);
  assign wr_cnt  = we_i && (addr_i == RA_CNT);
  assign wr_data = we_i && (addr_i == RA_DATA);
  assign wr_ctrl = we_i && (addr_i == RA_CTRL);
  assign wr_stat = we_i && (addr_i == RA_STAT);

  assign go_o = wr_ctrl && wdata_i[CTRL_GO] && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_o  <= '0;
      cmd_o  <= '0;
      cnt_o  <= '0;
      data_o <= '0;
      ie_o   <= 1'b0;
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      if (wr_tgt) tgt_o <= wdata_i;
      if (wr_cmd) cmd_o <= wdata_i;
      if (wr_ctrl) ie_o <= wdata_i[CTRL_IE];
      // hardware store beats a same-cycle software write
      if (hw_cnt_we_i)      cnt_o <= hw_byte_i;
      else if (wr_cnt)      cnt_o <= wdata_i;
      if (hw_data_we_i)     data_o <= hw_byte_i;
      else if (wr_data)     data_o <= wdata_i;
      if (hw_done_set_i)    done_o <= 1'b1;
      else if (go_o)        done_o <= 1'b0;
      else if (wr_stat && wdata_i[STAT_DONE]) done_o <= 1'b0;
      if (hw_err_set_i)     err_o <= 1'b1;
      else if (go_o)        err_o <= 1'b0;
      else if (wr_stat && wdata_i[STAT_ERR]) err_o <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      RA_TGT:  rdata_o = tgt_o;
      RA_CMD:  rdata_o = cmd_o;
      RA_CNT:  rdata_o = cnt_o;
      RA_DATA: rdata_o = data_o;
      RA_CTRL: rdata_o[CTRL_IE] = ie_o;
      RA_STAT: begin
        rdata_o[STAT_DONE] = done_o;
        rdata_o[STAT_ERR]  = err_o;
        rdata_o[STAT_BUSY] = busy_i;
      end
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/smb_blk_seq.sv
module smb_blk_seq
  import smb_blk_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [DW-1:0] tgt_i,
  input  logic [DW-1:0] cmd_i,
  input  logic [DW-1:0] cnt_i,
  input  logic [DW-1:0] data_i,
  input  logic          done_i,
  input  logic          phy_done_i,
  input  logic          phy_nack_i,
  input  logic [DW-1:0] phy_rbyte_i,
  output logic          phy_req_o,
  output logic [2:0]    phy_op_o,
  output logic [DW-1:0] phy_byte_o,
  output logic          scl_hold_o,
  output logic          busy_o,
  output logic          set_done_o,
  output logic          set_err_o,
  output logic          cnt_we_o,
  output logic          data_we_o
);
  seq_st_e       st_q, st_d;
  logic [DW-1:0] rem_q, rem_d;
  logic          pend_q;
  phy_op_e       op;
  logic          op_st, ev, last, zero_wr, zero_rd, nack_ev, rx_zero;

  assign ev      = pend_q && phy_done_i;
  assign last    = (rem_q == DW'(1));
  assign rx_zero = (phy_rbyte_i == '0);
  assign zero_wr = go_i && !tgt_i[0] && (cnt_i == '0);
  assign zero_rd = ev && (st_q == ST_RCNT) && rx_zero;
  assign nack_ev = ev && phy_nack_i &&
                   ((st_q == ST_ADR) || (st_q == ST_CMD) || (st_q == ST_CNT) ||
                    (st_q == ST_WDAT) || (st_q == ST_RSTA));

  always_comb begin
    op         = OP_STOP;
    phy_byte_o = '0;
    op_st      = 1'b1;
    case (st_q)
      ST_ADR:   begin op = OP_START; phy_byte_o = {tgt_i[DW-1:1], 1'b0}; end
      ST_CMD:   begin op = OP_WRITE; phy_byte_o = cmd_i; end
      ST_CNT:   begin op = OP_WRITE; phy_byte_o = cnt_i; end
      ST_WDAT:  begin op = OP_WRITE; phy_byte_o = data_i; end
      ST_RSTA:  begin op = OP_START; phy_byte_o = {tgt_i[DW-1:1], 1'b1}; end
      ST_RCNT:  op = OP_READ;
      ST_RCACK: op = OP_ACK;
      ST_RZNAK: op = OP_NACK;
      ST_RDAT:  op = OP_READ;
      ST_RACK:  op = last ? OP_NACK : OP_ACK;
      ST_STOP:  op = OP_STOP;
      default:  op_st = 1'b0;
    endcase
  end

  assign phy_op_o   = op;
  assign phy_req_o  = op_st && !pend_q;
  assign scl_hold_o = (st_q == ST_WWAIT) || (st_q == ST_RWAIT);
  assign busy_o     = (st_q != ST_IDLE);
  assign set_err_o  = ((st_q == ST_IDLE) && zero_wr) || nack_ev || zero_rd;
  assign set_done_o = ev && (((st_q == ST_WDAT) && !phy_nack_i) || (st_q == ST_RDAT));
  assign cnt_we_o   = ev && (st_q == ST_RCNT) && !rx_zero;
  assign data_we_o  = ev && (st_q == ST_RDAT);

  always_comb begin
    st_d  = st_q;
    rem_d = rem_q;
    case (st_q)
      ST_IDLE:  if (go_i && !zero_wr) begin st_d = ST_ADR; rem_d = cnt_i; end
      ST_ADR:   if (ev) st_d = phy_nack_i ? ST_STOP : ST_CMD;
      ST_CMD:   if (ev) st_d = phy_nack_i ? ST_STOP : (tgt_i[0] ? ST_RSTA : ST_CNT);
      ST_CNT:   if (ev) st_d = phy_nack_i ? ST_STOP : ST_WDAT;
      ST_WDAT:  if (ev) begin
        if (phy_nack_i) st_d = ST_STOP;
        else begin
          rem_d = rem_q - DW'(1);
          st_d  = last ? ST_STOP : ST_WWAIT;
        end
      end
      ST_WWAIT: if (!done_i) st_d = ST_WDAT;
      ST_RSTA:  if (ev) st_d = phy_nack_i ? ST_STOP : ST_RCNT;
      ST_RCNT:  if (ev) begin
        if (rx_zero) st_d = ST_RZNAK;
        else begin rem_d = phy_rbyte_i; st_d = ST_RCACK; end
      end
      ST_RCACK: if (ev) st_d = ST_RDAT;
      ST_RZNAK: if (ev) st_d = ST_STOP;
      ST_RDAT:  if (ev) st_d = ST_RWAIT;
      ST_RWAIT: if (!done_i) st_d = ST_RACK;
      ST_RACK:  if (ev) begin
        rem_d = rem_q - DW'(1);
        st_d  = last ? ST_STOP : ST_RDAT;
      end
      ST_STOP:  if (ev) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      rem_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      rem_q <= rem_d;
      if (phy_req_o) pend_q <= 1'b1;
      else if (ev)   pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/smb_blk_xfer.sv
module smb_blk_xfer
  import smb_blk_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              irq_o,
  output logic              phy_req_o,
  output logic [2:0]        phy_op_o,
  output logic [DW-1:0]     phy_byte_o,
  input  logic              phy_done_i,
  input  logic              phy_nack_i,
  input  logic [DW-1:0]     phy_rbyte_i,
  output logic              scl_hold_o
);
  logic [DW-1:0] tgt, cmd, cnt, data;
  logic          byte_done, err, irq_en, go, busy;
  logic          set_done, set_err, cnt_we, data_we;

  smb_blk_regs #(.DW(DW)) i_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .we_i          (reg_we_i),
    .addr_i        (reg_addr_i),
    .wdata_i       (reg_wdata_i),
    .rdata_o       (reg_rdata_o),
    .busy_i        (busy),
    .hw_done_set_i (set_done),
    .hw_err_set_i  (set_err),
    .hw_cnt_we_i   (cnt_we),
    .hw_data_we_i  (data_we),
    .hw_byte_i     (phy_rbyte_i),
    .tgt_o         (tgt),
    .cmd_o         (cmd),
    .cnt_o         (cnt),
    .data_o        (data),
    .done_o        (byte_done),
    .err_o         (err),
    .ie_o          (irq_en),
    .go_o          (go)
  );

  smb_blk_seq #(.DW(DW)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (go),
    .tgt_i       (tgt),
    .cmd_i       (cmd),
    .cnt_i       (cnt),
    .data_i      (data),
    .done_i      (byte_done),
    .phy_done_i  (phy_done_i),
    .phy_nack_i  (phy_nack_i),
    .phy_rbyte_i (phy_rbyte_i),
    .phy_req_o   (phy_req_o),
    .phy_op_o    (phy_op_o),
    .phy_byte_o  (phy_byte_o),
    .scl_hold_o  (scl_hold_o),
    .busy_o      (busy),
    .set_done_o  (set_done),
    .set_err_o   (set_err),
    .cnt_we_o    (cnt_we),
    .data_we_o   (data_we)
  );

  assign irq_o = byte_done && irq_en;
endmodule

// File: rtl/smb_blk_chk.sv
module smb_blk_chk
  import smb_blk_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       phy_req_o,
  input logic [2:0] phy_op_o,
  input logic       irq_o,
  input logic       byte_done,
  input logic       irq_en,
  input logic       busy,
  input logic       err,
  input logic       go,
  input logic       dir_rd,
  input logic       cnt_zero,
  input logic       ctrl_wr,
  input logic       go_bit
);
  // R12
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_req_o |=> !phy_req_o);

  // R3
  wr_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phy_req_o && phy_op_o == OP_WRITE) |-> !byte_done);

  // R5
  ack_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phy_req_o && (phy_op_o == OP_ACK || phy_op_o == OP_NACK)) |-> !byte_done);

  // R9
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en |-> !irq_o);

  // R6
  zero_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && !dir_rd && cnt_zero) |=> (!busy && err));

  // R10
  busy_go_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && ctrl_wr && go_bit && byte_done) |=> byte_done);
endmodule

bind smb_blk_xfer smb_blk_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .phy_req_o (phy_req_o),
  .phy_op_o  (phy_op_o),
  .irq_o     (irq_o),
  .byte_done (byte_done),
  .irq_en    (irq_en),
  .busy      (busy),
  .err       (err),
  .go        (go),
  .dir_rd    (tgt[0]),
  .cnt_zero  (cnt == '0),
  .ctrl_wr   (reg_we_i && (reg_addr_i == smb_blk_pkg::RA_CTRL)),
  .go_bit    (reg_wdata_i[smb_blk_pkg::CTRL_GO])
);

// File: tb/test_smb_blk_xfer.sv
module test_smb_blk_xfer;
  import smb_blk_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_o, phy_req_o, scl_hold_o;
  logic [2:0] phy_op_o;
  logic [7:0] phy_byte_o;
  logic       phy_done = 1'b0, phy_nack = 1'b0;
  logic [7:0] phy_rbyte = '0;

  int n_chk = 0, n_fail = 0;
  logic [2:0] log_op[128];
  logic [7:0] log_byte[128];
  int log_n = 0;
  logic [2:0] e_op[128];
  logic [7:0] e_byte[128];
  int e_n = 0;
  logic [7:0] slv[64];
  int slv_i = 0;
  logic [7:0] wdat[16];
  int lat = 1;
  int nack_op = -1;
  logic [2:0] cur_op;

  always #(CLK_PERIOD/2) clk = ~clk;

  smb_blk_xfer i_smb_blk_xfer (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .irq_o(irq_o), .phy_req_o(phy_req_o), .phy_op_o(phy_op_o), .phy_byte_o(phy_byte_o),
    .phy_done_i(phy_done), .phy_nack_i(phy_nack), .phy_rbyte_i(phy_rbyte),
    .scl_hold_o(scl_hold_o)
  );

  // bit-level master model
  initial begin
    forever begin
      @(negedge clk);
      while (phy_req_o) begin
        cur_op = phy_op_o;
        log_op[log_n] = phy_op_o;
        log_byte[log_n] = phy_byte_o;
        log_n++;
        repeat (lat) @(negedge clk);
        phy_rbyte = (cur_op == OP_READ) ? slv[slv_i] : 8'h00;
        if (cur_op == OP_READ) slv_i++;
        phy_nack = ((cur_op == OP_START) || (cur_op == OP_WRITE)) && (log_n - 1 == nack_op);
        phy_done = 1'b1;
        @(negedge clk);
        phy_done = 1'b0;
        phy_nack = 1'b0;
      end
    end
  end

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_done();
    logic [7:0] s;
    do reg_rd(RA_STAT, s); while (!s[STAT_DONE]);
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    do reg_rd(RA_STAT, s); while (s[STAT_BUSY]);
  endtask

  task automatic e_add(input logic [2:0] op, input logic [7:0] b);
    e_op[e_n] = op; e_byte[e_n] = b; e_n++;
  endtask

  task automatic cmp_log(input string req);
    chk(req, "op count", log_n, e_n);
    for (int i = 0; i < e_n; i++) begin
      chk(req, $sformatf("op %0d code", i), int'(log_op[i]), int'(e_op[i]));
      if (e_op[i] == OP_START || e_op[i] == OP_WRITE)
        chk(req, $sformatf("op %0d byte", i), int'(log_byte[i]), int'(e_byte[i]));
    end
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] c, input int n,
                          input logic ie, input logic poke);
    logic [7:0] s;
    int held;
    log_n = 0;
    reg_wr(RA_TGT, {a, 1'b0});
    reg_wr(RA_CMD, c);
    reg_wr(RA_CNT, 8'(n));
    reg_wr(RA_DATA, wdat[0]);
    reg_wr(RA_CTRL, {6'b0, ie, 1'b1});
    reg_rd(RA_CTRL, s);
    chk("R1", "ctrl readback", int'(s), int'({6'b0, ie, 1'b0}));
    for (int k = 1; k < n; k++) begin
      wait_done();
      chk("R9", "irq while done", int'(irq_o), int'(ie));
      chk("R3", "scl hold while waiting", int'(scl_hold_o), 1);
      held = log_n;
      repeat (5) @(negedge clk);
      chk("R3", "no request before clear", log_n, held);
      if (poke && k == 1) begin
        reg_wr(RA_CTRL, 8'h03);
        reg_rd(RA_STAT, s);
        chk("R10", "start while busy keeps done", int'(s), 8'h05);
      end
      reg_wr(RA_DATA, wdat[k]);
      reg_wr(RA_STAT, 8'h01);
      if (k == 1) begin
        @(negedge clk);
        chk("R9", "irq low after clear", int'(irq_o), 0);
      end
    end
    wait_idle();
    e_n = 0;
    e_add(OP_START, {a, 1'b0});
    e_add(OP_WRITE, c);
    e_add(OP_WRITE, 8'(n));
    for (int k = 0; k < n; k++) e_add(OP_WRITE, wdat[k]);
    e_add(OP_STOP, 8'h00);
    cmp_log("R2");
    reg_rd(RA_STAT, s);
    chk("R11", "write end status", int'(s), 8'h01);
  endtask

  task automatic do_read(input logic [6:0] a, input logic [7:0] c, input int n,
                         input logic ie, input logic collide, input logic hold);
    logic [7:0] s;
    int held;
    log_n = 0;
    slv_i = 0;
    slv[0] = 8'(n);
    reg_wr(RA_TGT, {a, 1'b1});
    reg_wr(RA_CMD, c);
    reg_wr(RA_CTRL, {6'b0, ie, 1'b1});
    if (collide) begin
      do begin @(negedge clk); #1; end while (log_n < 4);
      repeat (lat - 1) @(negedge clk);
      reg_wr(RA_CNT, 8'hEE);
    end
    for (int k = 0; k < n; k++) begin
      wait_done();
      reg_rd(RA_DATA, s);
      chk("R5", $sformatf("data byte %0d", k), int'(s), int'(slv[k+1]));
      reg_rd(RA_CNT, s);
      chk(collide ? "R11" : "R4", "received count", int'(s), n);
      chk("R9", "irq while done", int'(irq_o), int'(ie));
      if (hold && k == 0) begin
        held = log_n;
        repeat (6) @(negedge clk);
        chk("R5", "no ack before clear", log_n, held);
        chk("R5", "scl hold while waiting", int'(scl_hold_o), 1);
      end
      reg_wr(RA_STAT, 8'h01);
    end
    wait_idle();
    e_n = 0;
    e_add(OP_START, {a, 1'b0});
    e_add(OP_WRITE, c);
    e_add(OP_START, {a, 1'b1});
    e_add(OP_READ, 8'h00);
    e_add(OP_ACK, 8'h00);
    for (int k = 0; k < n; k++) begin
      e_add(OP_READ, 8'h00);
      e_add((k == n - 1) ? OP_NACK : OP_ACK, 8'h00);
    end
    e_add(OP_STOP, 8'h00);
    cmp_log("R4");
    reg_rd(RA_STAT, s);
    chk("R11", "read end status", int'(s), 8'h00);
  endtask

  initial begin
    logic [7:0] s;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk("R1", "irq after reset", int'(irq_o), 0);
    chk("R1", "req after reset", int'(phy_req_o), 0);
    rst_n = 1'b1;
    reg_rd(RA_STAT, s);
    chk("R1", "status after reset", int'(s), 0);
    chk("R1", "hold after reset", int'(scl_hold_o), 0);

    // R6 zero-count write
    log_n = 0;
    reg_wr(RA_TGT, 8'hA0);
    reg_wr(RA_CNT, 8'h00);
    reg_wr(RA_CTRL, 8'h01);
    reg_rd(RA_STAT, s);
    chk("R6", "zero write status", int'(s), 8'h02);
    repeat (5) @(negedge clk);
    chk("R6", "zero write no ops", log_n, 0);

    // directed write with busy start poke (also clears previous error, R11)
    for (int k = 0; k < 16; k++) wdat[k] = 8'(8'h30 + k);
    do_write(7'h2A, 8'h5C, 4, 1'b1, 1'b1);

    // R7 zero-count read
    log_n = 0; slv_i = 0; slv[0] = 8'h00;
    reg_wr(RA_TGT, 8'h91);
    reg_wr(RA_CMD, 8'h11);
    reg_wr(RA_CTRL, 8'h01);
    wait_idle();
    e_n = 0;
    e_add(OP_START, 8'h90); e_add(OP_WRITE, 8'h11); e_add(OP_START, 8'h91);
    e_add(OP_READ, 8'h00); e_add(OP_NACK, 8'h00); e_add(OP_STOP, 8'h00);
    cmp_log("R7");
    reg_rd(RA_STAT, s);
    chk("R7", "zero read status", int'(s), 8'h02);

    // R8 slave nack on command byte
    log_n = 0; nack_op = 1;
    reg_wr(RA_TGT, 8'h40);
    reg_wr(RA_CMD, 8'h77);
    reg_wr(RA_CNT, 8'h03);
    reg_wr(RA_CTRL, 8'h01);
    wait_idle();
    nack_op = -1;
    e_n = 0;
    e_add(OP_START, 8'h40); e_add(OP_WRITE, 8'h77); e_add(OP_STOP, 8'h00);
    cmp_log("R8");
    reg_rd(RA_STAT, s);
    chk("R8", "nack status", int'(s), 8'h02);

    // R5 hold check and R11 collision on count
    lat = 2;
    for (int k = 1; k < 64; k++) slv[k] = 8'(8'hC0 ^ k);
    do_read(7'h33, 8'h21, 3, 1'b1, 1'b0, 1'b1);
    do_read(7'h34, 8'h22, 3, 1'b0, 1'b1, 1'b0);

    // boundary: single-byte transfers
    lat = 1;
    do_write(7'h01, 8'h02, 1, 1'b0, 1'b0);
    do_read(7'h7F, 8'hFF, 1, 1'b1, 1'b0, 1'b0);

    // constrained random mix
    for (int it = 0; it < 12; it++) begin
      int n;
      logic [6:0] a;
      logic [7:0] c;
      logic ie;
      lat = 1 + int'($urandom % 3);
      n = 1 + int'($urandom % 8);
      a = 7'($urandom);
      c = 8'($urandom);
      ie = 1'($urandom);
      if ($urandom % 2 == 0) begin
        for (int k = 0; k < 16; k++) wdat[k] = 8'($urandom);
        do_write(a, c, n, ie, 1'b0);
      end else begin
        for (int k = 1; k < 64; k++) slv[k] = 8'($urandom);
        do_read(a, c, n, ie, 1'b0, 1'b0);
      end
    end

    finish_up();
  end
endmodule